// File: doc/BRIEF.md
# Flash Read Response and Status Unit

This unit forms the read data of a parallel flash model. It answers each read strobe according to the mode that the command sequencer presents. In array mode it returns the stored bytes. In identification mode it returns the identifier words. In status mode it returns the operation status byte. In query mode it returns an entry of the parameter table. The array bytes arrive on a 32-bit input, least significant byte first. The unit trims them to the access size, so multi-byte reads come out in little-endian order.

The unit also holds the status byte and the busy timer for the embedded operations. A program request completes almost at once. A sector erase or a chip erase keeps the unit busy for a number of clock cycles set by a parameter. When an operation ends, a one-cycle done pulse goes to the sequencer. A flag beside the pulse tells the sequencer whether to return to read mode or to the bypass command state.

Identification and query accesses use a word index. The index is the low address byte divided by the device width in bytes.

Top module: `flash_rsp_unit`

## Requirements
- R1: After reset, rd_valid, rd_data, busy, done and done_to_bypass are all 0, and the first status read returns 8'h00.
- R2: A read strobe gives rd_valid and rd_data one cycle later. In array mode, rd_size 0 returns arr_data[7:0], rd_size 1 returns arr_data[15:0], and rd_size 2 or 3 returns all 32 bits, with the upper bits zero-filled.
- R3: In identification mode (mode 1), word index 0 returns ID_W0 and index 1 returns ID_W1. Index 2 returns 0, meaning no sector is protected. Index 14 returns ID_W2 and index 15 returns ID_W3. Every other index returns the sized array data.
- R4: In identification mode, index 14 or 15 returns the sized array data when its identifier parameter equals 16'hFFFF.
- R5: In status mode (mode 2), a read returns the status byte as it was before that read. Bit 6 of the status byte inverts after each status read.
- R6: When idle, a sector erase start (or a chip erase start) sets the status byte to 8'h00. It then holds busy high for SE_CYCLES (or CE_CYCLES) cycles. In the first cycle with busy low, done is high for exactly one cycle, and status bit 7 has been inverted at that moment.
- R7: When idle, a program start sets the status byte to 8'h7F if prog_msb is 1, or to 8'hFF if it is 0. Busy is then high for one cycle, and done follows in the next cycle.
- R8: done_to_bypass is high together with done exactly when bypass_on was high in the last busy cycle.
- R9: A start of any kind that arrives while busy is high is ignored. It leaves the busy length and the status byte unchanged.
- R10: In query mode (mode 3), word indices 8'h10 to 8'h12 return 8'h51, 8'h52 and 8'h59. Index 8'h27 returns log2 of SECT_BYTES*NSECT. Indices 8'h2D and 8'h2E return NSECT-1, low byte then high byte. Indices 8'h2F and 8'h30 return bits 15:8 and 23:16 of SECT_BYTES. Indices 8'h52 and above return 0.
- R11: A status read in the final busy cycle of an erase returns the value before completion. Afterwards, the status byte carries both the bit 6 flip and the bit 7 flip.
- R12: The identification and query word index is rd_ofs divided by DEV_BYTES. Address bits below the device width do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read request |
| rd_ofs | input | 8 | Low byte of the read address |
| rd_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| mode | input | 2 | 0 array, 1 identification, 2 status, 3 query |
| arr_data | input | 32 | Array bytes at the address, lowest address in bits 7:0 |
| bypass_on | input | 1 | Bypass mode active in the sequencer |
| start_prog | input | 1 | Program start pulse |
| prog_msb | input | 1 | Bit 7 of the programmed data |
| start_serase | input | 1 | Sector erase start pulse |
| start_cerase | input | 1 | Chip erase start pulse |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data updated this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_to_bypass | output | 1 | With done: return to the bypass command state |

## Verification
Two functions can act in the same cycle: the bit 6 toggle of a status read and the bit 7 inversion at the end of an erase. The bench provokes this by starting a chip erase and then issuing status reads back to back, exactly CE_CYCLES of them. The last read is therefore strobed in the final busy cycle. Each returned byte is compared with a model that applies the toggle after every read. The byte read after done is compared with the model after both flips. A start injected in the middle of a sector erase is judged by the busy length and by the status byte read afterwards.

// File: rtl/flash_rsp_pkg.sv
package flash_rsp_pkg;
  typedef enum logic [1:0] {
    MD_ARRAY  = 2'd0,
    MD_IDENT  = 2'd1,
    MD_STATUS = 2'd2,
    MD_QUERY  = 2'd3
  } rsp_mode_e;

  localparam logic [7:0] QUERY_LEN = 8'h52;
  localparam logic [15:0] ID_UNUSED = 16'hFFFF;
endpackage

// File: rtl/flash_busy_status.sv
module flash_busy_status #(
  parameter int unsigned CE_CYCLES = 1250000000,
  parameter int unsigned SE_CYCLES = 125000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_prog,
  input  logic       prog_msb,
  input  logic       go_serase,
  input  logic       go_cerase,
  input  logic       stat_rd,
  input  logic       bypass_on,
  output logic [7:0] stat_q,
  output logic       busy_q,
  output logic       done_q,
  output logic       done_byp_q
);
  localparam int unsigned MAXC = (CE_CYCLES > SE_CYCLES) ? CE_CYCLES : SE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          erase_q;
  logic          fin;
  logic [7:0]    stat_nxt;

  assign fin = busy_q && (cnt_q == '0);

  always_comb begin
    stat_nxt = stat_q;
    if (fin && erase_q) stat_nxt[7] = ~stat_nxt[7];
    if (stat_rd)        stat_nxt[6] = ~stat_nxt[6];
    if (!busy_q) begin
      if (go_cerase || go_serase) stat_nxt = 8'h00;
      else if (go_prog)           stat_nxt = {~prog_msb, 7'h7F};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q     <= 8'h00;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      erase_q    <= 1'b0;
      done_q     <= 1'b0;
      done_byp_q <= 1'b0;
    end else begin
      stat_q     <= stat_nxt;
      done_q     <= fin;
      done_byp_q <= fin && bypass_on;
      if (!busy_q) begin
        if (go_cerase) begin
          busy_q  <= 1'b1;
          erase_q <= 1'b1;
          cnt_q   <= CW'(CE_CYCLES - 1);
        end else if (go_serase) begin
          busy_q  <= 1'b1;
          erase_q <= 1'b1;
          cnt_q   <= CW'(SE_CYCLES - 1);
        end else if (go_prog) begin
          busy_q  <= 1'b1;
          erase_q <= 1'b0;
          cnt_q   <= '0;
        end
      end else if (fin) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_id_map.sv
module flash_id_map
  import flash_rsp_pkg::*;
#(
  parameter logic [15:0] ID_W0 = 16'h0001,
  parameter logic [15:0] ID_W1 = 16'h227E,
  parameter logic [15:0] ID_W2 = 16'h2210,
  parameter logic [15:0] ID_W3 = 16'h2201
) (
  input  logic [7:0]  widx,
  output logic        id_hit,
  output logic [15:0] id_val
);
  always_comb begin
    id_hit = 1'b0;
    id_val = 16'h0000;
    case (widx)
      8'h00: begin id_hit = 1'b1; id_val = ID_W0; end
      8'h01: begin id_hit = 1'b1; id_val = ID_W1; end
      8'h02: begin id_hit = 1'b1; id_val = 16'h0000; end
      8'h0E: begin id_hit = (ID_W2 != ID_UNUSED); id_val = ID_W2; end
      8'h0F: begin id_hit = (ID_W3 != ID_UNUSED); id_val = ID_W3; end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_query_rom.sv
module flash_query_rom
  import flash_rsp_pkg::*;
#(
  parameter int unsigned SECT_BYTES = 65536,
  parameter int unsigned NSECT      = 64
) (
  input  logic [7:0] widx,
  output logic [7:0] qval
);
  localparam longint unsigned CHIP_BYTES = longint'(SECT_BYTES) * longint'(NSECT);
  localparam int unsigned     LOG2_CHIP  = $clog2(CHIP_BYTES);
  localparam logic [15:0]     NS_M1      = 16'(NSECT - 1);
  localparam logic [31:0]     SB         = 32'(SECT_BYTES);

  always_comb begin
    qval = 8'h00;
    if (widx < QUERY_LEN) begin
      case (widx)
        8'h10: qval = 8'h51;
        8'h11: qval = 8'h52;
        8'h12: qval = 8'h59;
        8'h13: qval = 8'h02;
        8'h15: qval = 8'h31;
        8'h1B: qval = 8'h27;
        8'h1C: qval = 8'h36;
        8'h1F: qval = 8'h07;
        8'h21: qval = 8'h09;
        8'h22: qval = 8'h0C;
        8'h23: qval = 8'h01;
        8'h25: qval = 8'h0A;
        8'h26: qval = 8'h0D;
        8'h27: qval = 8'(LOG2_CHIP);
        8'h28: qval = 8'h02;
        8'h2C: qval = 8'h01;
        8'h2D: qval = NS_M1[7:0];
        8'h2E: qval = NS_M1[15:8];
        8'h2F: qval = SB[15:8];
        8'h30: qval = SB[23:16];
        8'h31: qval = 8'h50;
        8'h32: qval = 8'h52;
        8'h33: qval = 8'h49;
        8'h34: qval = 8'h31;
        8'h35: qval = 8'h30;
        default: qval = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_rsp_unit.sv
module flash_rsp_unit
  import flash_rsp_pkg::*;
#(
  parameter int unsigned DEV_BYTES  = 2,
  parameter int unsigned SECT_BYTES = 65536,
  parameter int unsigned NSECT      = 64,
  parameter int unsigned CE_CYCLES  = 1250000000,
  parameter int unsigned SE_CYCLES  = 125000000,
  parameter logic [15:0] ID_W0      = 16'h0001,
  parameter logic [15:0] ID_W1      = 16'h227E,
  parameter logic [15:0] ID_W2      = 16'h2210,
  parameter logic [15:0] ID_W3      = 16'h2201
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_stb,
  input  logic [7:0]  rd_ofs,
  input  logic [1:0]  rd_size,
  input  logic [1:0]  mode,
  input  logic [31:0] arr_data,
  input  logic        bypass_on,
  input  logic        start_prog,
  input  logic        prog_msb,
  input  logic        start_serase,
  input  logic        start_cerase,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        busy,
  output logic        done,
  output logic        done_to_bypass
);
  localparam int unsigned IDX_SH = $clog2(DEV_BYTES);
  localparam int unsigned LANES  = 4;

  logic [7:0]  widx;
  logic [31:0] arr_sized;
  logic        id_hit;
  logic [15:0] id_val;
  logic [7:0]  q_val;
  logic [7:0]  stat_w;
  logic        stat_rd;
  logic [31:0] rsp_nxt;
  logic [31:0] rd_data_q;
  logic        rd_valid_q;

  assign widx    = rd_ofs >> IDX_SH;
  assign stat_rd = rd_stb && (rsp_mode_e'(mode) == MD_STATUS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned NEED = (g == 0) ? 0 : ((g == 1) ? 1 : 2);
    assign arr_sized[8*g +: 8] = (int'(rd_size) >= NEED) ? arr_data[8*g +: 8] : 8'h00;
  end

  flash_id_map #(
    .ID_W0(ID_W0), .ID_W1(ID_W1), .ID_W2(ID_W2), .ID_W3(ID_W3)
  ) id_i (
    .widx   (widx),
    .id_hit (id_hit),
    .id_val (id_val)
  );

  flash_query_rom #(
    .SECT_BYTES(SECT_BYTES), .NSECT(NSECT)
  ) rom_i (
    .widx (widx),
    .qval (q_val)
  );

  flash_busy_status #(
    .CE_CYCLES(CE_CYCLES), .SE_CYCLES(SE_CYCLES)
  ) bs_i (
    .clk        (clk),
    .rst        (rst),
    .go_prog    (start_prog),
    .prog_msb   (prog_msb),
    .go_serase  (start_serase),
    .go_cerase  (start_cerase),
    .stat_rd    (stat_rd),
    .bypass_on  (bypass_on),
    .stat_q     (stat_w),
    .busy_q     (busy),
    .done_q     (done),
    .done_byp_q (done_to_bypass)
  );

  always_comb begin
    case (rsp_mode_e'(mode))
      MD_IDENT:  rsp_nxt = id_hit ? {16'h0000, id_val} : arr_sized;
      MD_STATUS: rsp_nxt = {24'h000000, stat_w};
      MD_QUERY:  rsp_nxt = {24'h000000, q_val};
      default:   rsp_nxt = arr_sized;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= 32'h0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_stb;
      if (rd_stb) rd_data_q <= rsp_nxt;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/flash_rsp_unit_chk.sv
module flash_rsp_unit_chk #(
  parameter int unsigned DEV_BYTES = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        rd_stb,
  input logic [7:0]  rd_ofs,
  input logic [1:0]  mode,
  input logic        start_prog,
  input logic        start_serase,
  input logic        start_cerase,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        busy,
  input logic        done,
  input logic        done_to_bypass,
  input logic [7:0]  stat_q
);
  localparam int unsigned SH = $clog2(DEV_BYTES);
  logic [7:0] widx;
  logic       any_go;
  assign widx   = rd_ofs >> SH;
  assign any_go = start_prog || start_serase || start_cerase;

  assert_valid_follows_stb_R2: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  assert_valid_needs_stb_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(any_go));
  assert_erase_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && (start_serase || start_cerase)) |=> (stat_q == 8'h00));
  assert_status_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mode == 2'd2 && !busy && !any_go) |=> (stat_q[6] != $past(stat_q[6])));
  assert_query_oob_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mode == 2'd3 && widx >= 8'h52) |=> (rd_data == 32'h0));
  assert_bypass_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_to_bypass |-> done);
endmodule

bind flash_rsp_unit flash_rsp_unit_chk #(.DEV_BYTES(DEV_BYTES)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .rd_stb         (rd_stb),
  .rd_ofs         (rd_ofs),
  .mode           (mode),
  .start_prog     (start_prog),
  .start_serase   (start_serase),
  .start_cerase   (start_cerase),
  .rd_data        (rd_data),
  .rd_valid       (rd_valid),
  .busy           (busy),
  .done           (done),
  .done_to_bypass (done_to_bypass),
  .stat_q         (stat_w)
);

// File: tb/flash_rsp_unit_tb_top.sv
`timescale 1ns/1ps
module flash_rsp_unit_tb_top;
  localparam int unsigned DEVB = 2;
  localparam int unsigned SECB = 4096;
  localparam int unsigned NSEC = 16;
  localparam int unsigned CEC  = 40;
  localparam int unsigned SEC  = 12;
  localparam logic [15:0] I0 = 16'h0001, I1 = 16'h227E, I2 = 16'h2210, I3 = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_ofs = 8'h00;
  logic [1:0]  rd_size = 2'd0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] arr_data = 32'h0;
  logic        bypass_on = 1'b0;
  logic        start_prog = 1'b0, prog_msb = 1'b0, start_serase = 1'b0, start_cerase = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid, busy, done, done_to_bypass;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] m_stat;

  always #2 clk = ~clk;

  flash_rsp_unit #(
    .DEV_BYTES(DEVB), .SECT_BYTES(SECB), .NSECT(NSEC),
    .CE_CYCLES(CEC), .SE_CYCLES(SEC),
    .ID_W0(I0), .ID_W1(I1), .ID_W2(I2), .ID_W3(I3)
  ) dut_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_ofs(rd_ofs), .rd_size(rd_size),
    .mode(mode), .arr_data(arr_data), .bypass_on(bypass_on),
    .start_prog(start_prog), .prog_msb(prog_msb),
    .start_serase(start_serase), .start_cerase(start_cerase),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .done_to_bypass(done_to_bypass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] md, input logic [7:0] ofs, input logic [1:0] sz,
                    output logic [31:0] d);
    mode = md; rd_ofs = ofs; rd_size = sz; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] sized(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return a & 32'h000000FF;
    if (sz == 2'd1) return a & 32'h0000FFFF;
    return a;
  endfunction

  task automatic stat_check(input string req);
    logic [31:0] d;
    rd(2'd2, 8'h00, 2'd0, d);
    chk(req, d, {24'h0, m_stat});
    m_stat[6] = ~m_stat[6];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] d, e, pat;
    int cnt, l2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 done", {30'h0, done, done_to_bypass}, 32'h0);
    m_stat = 8'h00;
    stat_check("R1/R5 status after reset");
    stat_check("R5 bit6 toggled");

    // R2 array reads, all sizes, several patterns
    for (int p = 0; p < 6; p++) begin
      pat = (32'(p) * 32'h1F3D5B79) ^ 32'hA5C3E10F;
      arr_data = pat;
      for (int s = 0; s < 4; s++) begin
        rd(2'd0, 8'(p * 7), 2'(s), d);
        chk("R2 array read", d, sized(pat, 2'(s)));
        chk("R2 rd_valid", {31'h0, rd_valid}, 32'h1);
      end
    end

    // R3 R4 R12 identification sweep
    for (int b = 0; b < 128; b++) begin
      pat = (32'(b) * 32'h01010101) ^ 32'h00FF00A5;
      arr_data = pat;
      rd(2'd1, 8'(b * DEVB + ((b % 3 == 0) ? 1 : 0)), 2'd1, d);
      case (b)
        0:  e = {16'h0, I0};
        1:  e = {16'h0, I1};
        2:  e = 32'h0;
        14: e = (I2 == 16'hFFFF) ? sized(pat, 2'd1) : {16'h0, I2};
        15: e = (I3 == 16'hFFFF) ? sized(pat, 2'd1) : {16'h0, I3};
        default: e = sized(pat, 2'd1);
      endcase
      if (b == 15) chk("R4 invalid id falls back to array", d, e);
      else chk("R3/R12 id map", d, e);
    end

    // R10 R12 query table
    l2 = 0;
    for (int v = SECB * NSEC; v > 1; v = v / 2) l2++;
    for (int b = 0; b < 128; b++) begin
      logic chkit;
      chkit = 1'b1;
      case (b)
        16'h10: e = 32'h51;
        16'h11: e = 32'h52;
        16'h12: e = 32'h59;
        16'h27: e = 32'(l2);
        16'h2D: e = (NSEC - 1) % 256;
        16'h2E: e = (NSEC - 1) / 256;
        16'h2F: e = (SECB / 256) % 256;
        16'h30: e = (SECB / 65536) % 256;
        default: begin e = 32'h0; chkit = (b >= 16'h52); end
      endcase
      rd(2'd3, 8'(b * DEVB + (b % 2)), 2'd0, d);
      if (chkit) chk("R10/R12 query entry", d, e);
    end

    // R7 program, msb 1
    prog_msb = 1'b1; start_prog = 1'b1;
    @(negedge clk); start_prog = 1'b0;
    chk("R7 busy one cycle", {30'h0, busy, done}, 32'h2);
    @(negedge clk);
    chk("R7 done after program", {30'h0, busy, done}, 32'h1);
    chk("R8 no bypass", {31'h0, done_to_bypass}, 32'h0);
    m_stat = 8'h7F;
    stat_check("R7 status msb1");

    // R7 R8 program, msb 0, bypass active
    bypass_on = 1'b1; prog_msb = 1'b0; start_prog = 1'b1;
    @(negedge clk); start_prog = 1'b0;
    @(negedge clk);
    chk("R8 done_to_bypass", {30'h0, done, done_to_bypass}, 32'h3);
    m_stat = 8'hFF;
    stat_check("R7 status msb0");
    bypass_on = 1'b0;

    // R6 R9 sector erase with start injected while busy
    start_serase = 1'b1;
    @(negedge clk); start_serase = 1'b0;
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == 3) begin start_prog = 1'b1; prog_msb = 1'b0; start_cerase = 1'b1; end
      if (cnt == 4) begin start_prog = 1'b0; start_cerase = 1'b0; end
      @(negedge clk);
    end
    chk("R6/R9 sector busy length", cnt, SEC);
    chk("R6 done pulse", {30'h0, done, done_to_bypass}, 32'h2);
    @(negedge clk);
    chk("R6 done one cycle", {31'h0, done}, 32'h0);
    m_stat = 8'h80;
    stat_check("R6/R9 status after sector erase");

    // R11 chip erase with status reads through the final busy cycle
    bypass_on = 1'b1;
    start_cerase = 1'b1;
    @(negedge clk); start_cerase = 1'b0;
    m_stat = 8'h00;
    for (int i = 0; i < CEC; i++) begin
      rd(2'd2, 8'h00, 2'd0, d);
      chk("R5/R11 status during chip erase", d, {24'h0, m_stat});
      m_stat[6] = ~m_stat[6];
    end
    chk("R6/R8 chip done with bypass", {29'h0, busy, done, done_to_bypass}, 32'h3);
    m_stat[7] = ~m_stat[7];
    stat_check("R11 both flips applied");
    bypass_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule